// File: doc/BRIEF.md
# Speculative Chunk Ordering Queue

This block keeps the global ordering of speculative work in a machine that runs loop iterations ahead of their sequential order. Work is grouped into chunks, each a run of consecutive thread indices; chunk k covers threads k*CHUNK_SIZE up to k*CHUNK_SIZE+CHUNK_SIZE-1. A free node asks for work and is handed the next unassigned chunk, which joins the most-speculative end of an in-order window. Because assignment follows whichever node becomes free, nodes finish out of order. Commit still runs strictly in chunk order: only the chunk at the least-speculative end may write back, and a node that finished a younger chunk waits until its chunk reaches the head.

Requests form a valid/ready stream. `req_ready` drops while the window holds WINDOW chunks, or during a start or squash cycle. A requester keeps `req_valid` and `req_node` steady until the handshake. The assigned chunk on `asg_chunk`/`asg_first_thread` is the value taken in the handshake cycle. Commits form a second valid/ready stream: `commit_valid` stays high with the same node and chunk until `commit_ready` is seen, and at most one chunk commits per clock. Start and squash are plain control pulses. A squash removes the named chunk and every younger one. Numbering then resumes at the squashed chunk, so the removed work is handed out again in order.

Top module: `chunk_order_queue`

## Requirements
- R1: After reset the window is empty: `commit_valid` is 0, `req_ready` is 1 and `asg_chunk` is 0.
- R2: Each accepted request (`req_valid` and `req_ready` both 1) is given chunk number `asg_chunk`, which starts at 0 and rises by one per accepted request. `asg_first_thread` equals `asg_chunk`*CHUNK_SIZE.
- R3: With WINDOW chunks active, `req_ready` is 0. A request then stalls until a commit frees a slot.
- R4: `commit_valid` is 1 only when the head chunk's node has reported done. `commit_node` and `commit_chunk` then name the head chunk and its owner.
- R5: A chunk finished before an older chunk is not offered for commit. It is offered in the cycle after the older chunk's commit handshake.
- R6: While `commit_ready` is 0, `commit_valid`, `commit_node` and `commit_chunk` hold steady. Successive commits carry consecutive chunk numbers, one per clock at most.
- R7: A done pulse (`done_valid`) names a node through `done_node`. It marks that node's single unfinished chunk as done. A done pulse for a node with no unfinished chunk changes nothing.
- R8: A squash of an active chunk removes that chunk and all younger ones and keeps the older ones. The next request is given the squashed chunk number.
- R9: A squash naming a chunk that is not active leaves both the window and the next chunk number unchanged.
- R10: In a cycle with `squash_valid` high, `req_ready` and `commit_valid` are both 0.
- R11: A `start` pulse empties the window and restarts numbering at chunk 0, whatever the window held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new speculative section: empty the window, numbering from 0 |
| req_valid | input | 1 | A free node asks for a chunk |
| req_ready | output | 1 | The request can be accepted this cycle |
| req_node | input | NODE_W | Id of the requesting node |
| asg_chunk | output | CHUNK_W | Chunk number handed out at a request handshake |
| asg_first_thread | output | CHUNK_W+log2(CHUNK_SIZE) | First thread index of that chunk |
| done_valid | input | 1 | A node has finished its current chunk |
| done_node | input | NODE_W | Id of the finishing node |
| commit_valid | output | 1 | The head chunk is finished and may be written back |
| commit_ready | input | 1 | The owner accepts the commit; the head chunk is removed |
| commit_node | output | NODE_W | Node granted the commit |
| commit_chunk | output | CHUNK_W | Chunk being committed |
| squash_valid | input | 1 | Squash the named chunk and all younger chunks |
| squash_chunk | input | CHUNK_W | Oldest chunk to squash |

## Verification
The assertions assume that each node holds at most one unfinished chunk: a node requests only after it has reported done on its previous chunk, or after that chunk has been squashed. They also assume that the chunk counter does not wrap within a run. The stimulus is built around that rule. Every node issues done before it requests again. The full-window scenario cycles through the node ids, so that only the last chunk stays unfinished. Each scenario begins with a start pulse or from an empty window, with chunk numbers far below the counter's range.

// File: rtl/coq_pkg.sv
package coq_pkg;
  // Per-cycle operation chosen by the top-level priority decode.
  typedef enum logic [1:0] {
    OP_RUN    = 2'd0,
    OP_SQUASH = 2'd1,
    OP_START  = 2'd2
  } coq_op_e;
endpackage

// File: rtl/coq_slot.sv
module coq_slot #(
  parameter int NODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [NODE_W-1:0] alloc_node,
  input  logic              mark,
  output logic [NODE_W-1:0] node_q,
  output logic              done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q <= '0;
      done_q <= 1'b0;
    end else if (alloc) begin
      node_q <= alloc_node;
      done_q <= 1'b0;
    end else if (mark) begin
      done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/coq_issue.sv
module coq_issue #(
  parameter int CHUNK_W    = 16,
  parameter int CHUNK_SIZE = 4,
  parameter int THREAD_W   = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load,
  input  logic [CHUNK_W-1:0]  load_chunk,
  input  logic                advance,
  output logic [CHUNK_W-1:0]  chunk_q,
  output logic [THREAD_W-1:0] first_thread
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chunk_q <= '0;
    else if (clear)   chunk_q <= '0;
    else if (load)    chunk_q <= load_chunk;
    else if (advance) chunk_q <= chunk_q + 1'b1;
  end

  assign first_thread = THREAD_W'(chunk_q) * THREAD_W'(CHUNK_SIZE);
endmodule

// File: rtl/coq_window.sv
module coq_window #(
  parameter int WINDOW = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic             trunc,
  input  logic [CNT_W-1:0] trunc_count,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      count    <= '0;
    end else if (clear) begin
      head_ptr <= '0;
      count    <= '0;
    end else if (trunc) begin
      count <= trunc_count;
    end else begin
      if (pop) head_ptr <= head_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign tail_ptr = head_ptr + count[PTR_W-1:0];
  assign full     = (count == CNT_W'(WINDOW));
endmodule

// File: rtl/chunk_order_queue.sv
module chunk_order_queue #(
  parameter int NODES      = 4,
  parameter int WINDOW     = 8,
  parameter int CHUNK_SIZE = 4,
  parameter int CHUNK_W    = 16,
  localparam int NODE_W    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int THREAD_W  = CHUNK_W + ((CHUNK_SIZE > 1) ? $clog2(CHUNK_SIZE) : 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [NODE_W-1:0]   req_node,
  output logic [CHUNK_W-1:0]  asg_chunk,
  output logic [THREAD_W-1:0] asg_first_thread,
  input  logic                done_valid,
  input  logic [NODE_W-1:0]   done_node,
  output logic                commit_valid,
  input  logic                commit_ready,
  output logic [NODE_W-1:0]   commit_node,
  output logic [CHUNK_W-1:0]  commit_chunk,
  input  logic                squash_valid,
  input  logic [CHUNK_W-1:0]  squash_chunk
);
  import coq_pkg::*;

  localparam int PTR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int CNT_W = PTR_W + 1;

  coq_op_e            op;
  logic [PTR_W-1:0]   head_ptr;
  logic [PTR_W-1:0]   tail_ptr;
  logic [CNT_W-1:0]   win_count;
  logic               win_full;
  logic [CHUNK_W-1:0] next_chunk;
  logic [CHUNK_W-1:0] head_chunk;
  logic [CHUNK_W-1:0] sq_off;
  logic               sq_hit;
  logic               req_fire;
  logic               commit_fire;
  logic [NODE_W-1:0]  slot_node [WINDOW];
  logic [WINDOW-1:0]  slot_done;
  logic [WINDOW-1:0]  slot_live;
  logic [WINDOW-1:0]  slot_hit;

  // Priority: start over squash over normal traffic.
  always_comb begin
    if (start)             op = OP_START;
    else if (squash_valid) op = OP_SQUASH;
    else                   op = OP_RUN;
  end

  assign head_chunk = next_chunk - CHUNK_W'(win_count);
  assign sq_off     = squash_chunk - head_chunk;
  assign sq_hit     = (op == OP_SQUASH) && (sq_off < CHUNK_W'(win_count));

  assign req_ready    = (op == OP_RUN) && !win_full;
  assign req_fire     = req_valid && req_ready;
  assign commit_valid = (op == OP_RUN) && (win_count != '0) && slot_done[head_ptr];
  assign commit_fire  = commit_valid && commit_ready;
  assign commit_node  = slot_node[head_ptr];
  assign commit_chunk = head_chunk;

  coq_window #(.WINDOW(WINDOW), .PTR_W(PTR_W), .CNT_W(CNT_W)) win_i (
    .clk(clk), .rst_n(rst_n),
    .clear(op == OP_START), .push(req_fire), .pop(commit_fire),
    .trunc(sq_hit), .trunc_count(sq_off[CNT_W-1:0]),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .count(win_count), .full(win_full)
  );

  coq_issue #(.CHUNK_W(CHUNK_W), .CHUNK_SIZE(CHUNK_SIZE), .THREAD_W(THREAD_W)) issue_i (
    .clk(clk), .rst_n(rst_n),
    .clear(op == OP_START), .load(sq_hit), .load_chunk(squash_chunk),
    .advance(req_fire), .chunk_q(next_chunk), .first_thread(asg_first_thread)
  );

  assign asg_chunk = next_chunk;

  for (genvar i = 0; i < WINDOW; i++) begin : g_slot
    logic [PTR_W-1:0] rel;
    assign rel          = PTR_W'(i) - head_ptr;
    assign slot_live[i] = CNT_W'(rel) < win_count;
    assign slot_hit[i]  = done_valid && slot_live[i] && !slot_done[i] &&
                          (slot_node[i] == done_node);

    coq_slot #(.NODE_W(NODE_W)) slot_i (
      .clk(clk), .rst_n(rst_n),
      .alloc(req_fire && (tail_ptr == PTR_W'(i))), .alloc_node(req_node),
      .mark(slot_hit[i]),
      .node_q(slot_node[i]), .done_q(slot_done[i])
    );
  end
endmodule

// File: rtl/coq_checker.sv
module coq_checker #(
  parameter int CHUNK_W = 16,
  parameter int NODE_W  = 2,
  parameter int CNT_W   = 4,
  parameter int WINDOW  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               req_valid,
  input logic               req_ready,
  input logic [CHUNK_W-1:0] asg_chunk,
  input logic               squash_valid,
  input logic [CHUNK_W-1:0] squash_chunk,
  input logic               commit_valid,
  input logic               commit_ready,
  input logic [NODE_W-1:0]  commit_node,
  input logic [CHUNK_W-1:0] commit_chunk,
  input logic [CNT_W-1:0]   win_count
);
  logic [CHUNK_W-1:0] oldest;
  logic               sq_in;
  assign oldest = asg_chunk - CHUNK_W'(win_count);
  assign sq_in  = (squash_chunk - oldest) < CHUNK_W'(win_count);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_count <= CNT_W'(WINDOW));

  // R2
  asg_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (asg_chunk == $past(asg_chunk) + 1'b1));

  // R6
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready) |=>
      (start || squash_valid || (commit_valid && $stable(commit_node) && $stable(commit_chunk))));

  // R6
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_ready) |=>
      (!commit_valid || (commit_chunk == $past(commit_chunk) + 1'b1)));

  // R8
  squash_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && !start && sq_in) |=> (asg_chunk == $past(squash_chunk)));

  // R9
  squash_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && !start && !sq_in) |=> (asg_chunk == $past(asg_chunk)));

  // R10
  squash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> (!req_ready && !commit_valid));

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (asg_chunk == '0 && win_count == '0));
endmodule

bind chunk_order_queue coq_checker #(
  .CHUNK_W(CHUNK_W), .NODE_W(NODE_W), .CNT_W(CNT_W), .WINDOW(WINDOW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start),
  .req_valid(req_valid), .req_ready(req_ready), .asg_chunk(asg_chunk),
  .squash_valid(squash_valid), .squash_chunk(squash_chunk),
  .commit_valid(commit_valid), .commit_ready(commit_ready),
  .commit_node(commit_node), .commit_chunk(commit_chunk),
  .win_count(win_count)
);

// File: tb/chunk_order_queue_tb.sv
module chunk_order_queue_tb_top;
  localparam int CS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_node = '0;
  logic [15:0] asg_chunk;
  logic [17:0] asg_first_thread;
  logic        done_valid = 1'b0;
  logic [1:0]  done_node = '0;
  logic        commit_valid;
  logic        commit_ready = 1'b0;
  logic [1:0]  commit_node;
  logic [15:0] commit_chunk;
  logic        squash_valid = 1'b0;
  logic [15:0] squash_chunk = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  chunk_order_queue #(.NODES(4), .WINDOW(8), .CHUNK_SIZE(CS), .CHUNK_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
    .asg_chunk(asg_chunk), .asg_first_thread(asg_first_thread),
    .done_valid(done_valid), .done_node(done_node),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_node(commit_node), .commit_chunk(commit_chunk),
    .squash_valid(squash_valid), .squash_chunk(squash_chunk)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, sample 1 ns later, apply at the next rising edge.
  task automatic do_req(input int node, input int exp_chunk, input string tag);
    req_valid = 1'b1; req_node = 2'(node); #1;
    chk({tag, " req_ready"}, req_ready, 1);
    chk({tag, " asg_chunk"}, asg_chunk, exp_chunk);
    chk({tag, " asg_first_thread"}, asg_first_thread, exp_chunk * CS);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic do_done(input int node);
    done_valid = 1'b1; done_node = 2'(node);
    @(negedge clk); done_valid = 1'b0;
  endtask

  task automatic do_commit(input int node, input int chunk, input string tag);
    commit_ready = 1'b1; #1;
    chk({tag, " commit_valid"}, commit_valid, 1);
    chk({tag, " commit_node"}, commit_node, node);
    chk({tag, " commit_chunk"}, commit_chunk, chunk);
    @(negedge clk); commit_ready = 1'b0;
  endtask

  task automatic no_commit(input string tag);
    #1; chk({tag, " commit_valid low"}, commit_valid, 0);
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 asg_chunk", asg_chunk, 0);
  endtask

  task automatic t_in_order();
    do_req(0, 0, "R2 first");
    do_req(1, 1, "R2 second");
    do_req(2, 2, "R2 third");
    do_done(1);
    no_commit("R5 younger done first");
    do_done(0);
    #1;
    chk("R4 head ready", commit_valid, 1);
    chk("R4 head node", commit_node, 0);
    chk("R4 head chunk", commit_chunk, 0);
    @(negedge clk); #1;
    chk("R6 hold valid", commit_valid, 1);
    chk("R6 hold chunk", commit_chunk, 0);
    @(negedge clk);
    do_commit(0, 0, "R4 commit head");
    do_commit(1, 1, "R5 waiting chunk next");
    no_commit("R4 unfinished head");
    do_done(2);
    do_commit(2, 2, "R6 third");
  endtask

  task automatic t_stray_done();
    do_done(3);
    do_req(3, 3, "R7 after stray done");
    no_commit("R7 stray done before request");
    do_done(1);
    no_commit("R7 node without chunk");
    do_done(3);
    do_commit(3, 3, "R7 real done");
  endtask

  task automatic t_full();
    do_start();
    #1;
    chk("R11 asg restart", asg_chunk, 0);
    chk("R11 window empty", commit_valid, 0);
    for (int i = 0; i < 8; i++) begin
      do_req(i % 4, i, "R3 fill");
      if (i < 7) do_done(i % 4);
    end
    req_valid = 1'b1; req_node = 2'd0; #1;
    chk("R3 full stalls", req_ready, 0);
    @(negedge clk); #1;
    chk("R3 still stalled", req_ready, 0);
    req_valid = 1'b0;
    do_commit(0, 0, "R3 free slot");
    do_req(0, 8, "R3 resumes");
    for (int i = 1; i < 7; i++) do_commit(i % 4, i, "R6 ordered drain");
    no_commit("R5 chunk 7 pending");
    do_done(0);
    no_commit("R5 chunk 8 waits");
    do_done(3);
    do_commit(3, 7, "R6 chunk 7");
    do_commit(0, 8, "R6 chunk 8");
  endtask

  task automatic t_squash();
    do_start();
    for (int i = 0; i < 4; i++) do_req(i, i, "R8 setup");
    do_done(0);
    squash_valid = 1'b1; squash_chunk = 16'd2; req_valid = 1'b1; req_node = 2'd2; #1;
    chk("R10 req blocked", req_ready, 0);
    chk("R10 commit blocked", commit_valid, 0);
    @(negedge clk);
    squash_valid = 1'b0; req_valid = 1'b0;
    do_req(2, 2, "R8 reissue squashed");
    squash_valid = 1'b1; squash_chunk = 16'd9;
    @(negedge clk); squash_valid = 1'b0;
    do_req(3, 3, "R9 out-of-range squash");
    do_commit(0, 0, "R8 older kept");
    no_commit("R8 chunk 1 unfinished");
    do_start();
    #1;
    chk("R11 start clears", commit_valid, 0);
    chk("R11 ready after start", req_ready, 1);
    chk("R11 numbering restart", asg_chunk, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_stray_done();
    t_full();
    t_squash();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule